// File: doc/BRIEF.md
# Guarded Clock Configuration Register Bank

This block holds the software-visible settings of a clock generation circuit: main clock stop and keep controls, CPU clock source bits, free divider fields, an oscillation-stop detector enable, the PLL enable and multiplier, the timer and serial clock selects, and a mode register. Every write reaches its register through a protect register. The protect register has one enable bit for the clock group and a separate enable bit for the mode register. Writes that the rules forbid are dropped without any error, and a one-cycle pulse reports each one. The current field values drive the clock tree directly as outputs.

The mode register carries two one-way options. The first is a lock that, once set, freezes the clock-source, stop and PLL settings until reset. The second moves the watchdog count source to the on-chip oscillator and disables stop-mode entry. It also holds a bus wait selection for special-register accesses. That selection applies only while the PLL runs and can be changed only while the PLL is off. The bus is a simple synchronous one: address, write data, write strobe, and combinational read data.

Top module: `ccr_bank`

## Requirements
- R1: After reset every field is 0, except the timer select (peripheral select bit 0) and the serial select (bit 1), which are both 1. The peripheral select register reads 0x03 and every other register reads 0x00.
- R2: The address map is protect 0, clock A 1, clock B 2, detector 3, PLL 4, peripheral select 5, mode 6. Protect bit 0 must be 1 for a write to clock A, clock B, detector, PLL or peripheral select to take effect. Protect bit 1 must be 1 for a write to the mode register to take effect. The protect register itself (bits 1:0) is always writable.
- R3: Mode bit 1 (lock) can be set by a write. Once it is 1, writing 0 to it does not clear it; only reset clears it.
- R4: While the lock is 1, these fields keep their values: clock A bits 0 (main stop), 1 (main keep) and 2 (CPU source A), clock B bit 1 (CPU source B), detector bit 0, and every PLL bit (bit 0 enable, bits 3:1 multiplier). The divider fields, clock A bits 7:4 and clock B bits 3:2, still accept writes.
- R5: Mode bit 2 (watchdog source on the on-chip oscillator) is one-way like the lock. While it is 1, a 1 written to clock B bit 0 starts no stop-mode entry.
- R6: Mode bit 0 (wait select, 1 = one wait, 0 = two waits) changes only on writes made while the PLL enable is 0. The one-wait output is 1 only when that bit and the PLL enable are both 1.
- R7: Reserved and unassigned bits read 0 regardless of what was written. Clock A bit 3, clock B bit 0 and the high bits of every register are such bits.
- R8: The blocked output is high for exactly one cycle, in the cycle after the write edge, for each write that is suppressed. A write is suppressed when it is refused by protect, or when the lock, watchdog-source or PLL-state rule keeps any bit from taking a written value that differs from its current value. A written 1 refused as a stop-mode entry also counts.
- R9: An accepted write of 1 to clock B bit 0 raises the stop output for one cycle after the write edge. The bit itself stores nothing.
- R10: Writes to unmapped addresses change nothing and give no pulse. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Register address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for addr, combinational |
| main_stop | output | 1 | Main clock stop |
| main_keep | output | 1 | Keep main clock running |
| cpu_src | output | 2 | CPU clock source {B, A} |
| div_a | output | DW-4 | Clock A divider field |
| div_b | output | 2 | Clock B divider field |
| osc_det_en | output | 1 | Oscillation-stop detector enable |
| pll_on | output | 1 | PLL enable |
| pll_mult | output | MULT_W | PLL multiplier |
| tmr_full | output | 1 | Timer clock undivided when 1 |
| ser_full | output | 1 | Serial clock undivided when 1 |
| sfr_one_wait | output | 1 | One-wait special-register access in effect |
| clk_locked | output | 1 | Lock bit |
| wdt_src_osc | output | 1 | Watchdog counts on-chip oscillator and keeps running in wait and hold |
| stop_go | output | 1 | One-cycle stop-mode entry request |
| wr_blocked | output | 1 | One-cycle suppressed-write pulse |

## Verification
Register fields and the two pulses change at the clock edge that samples the write. So the cycle right after a write shows the new value together with stop_go or wr_blocked, and the pulse is gone one cycle later. Read data follows the address within the same cycle, with no register in the path. A behavioural model in the bench updates at each rising edge. Outputs are compared against it a short delay after that edge, away from the negative edge where stimulus changes. The directed checks read back each pulse in the cycle after its write and read each register a settling delay after setting the address.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int unsigned NREG = 7;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_PROT, SEL_CLKA, SEL_CLKB,
      SEL_OSCD, SEL_PLL, SEL_PCLK, SEL_MODE
   } sel_e;

   typedef struct packed {
      logic       main_stop;
      logic       main_keep;
      logic       cpu_a;
      logic       cpu_b;
      logic [1:0] div_b;
      logic       det_en;
      logic       pll_on;
      logic       tmr_full;
      logic       ser_full;
      logic       wait1;
      logic       lock;
      logic       wdt_osc;
   } ccr_state_t;

   function automatic ccr_state_t ccr_reset_state();
      ccr_state_t s;
      s          = '0;
      s.tmr_full = 1'b1;
      s.ser_full = 1'b1;
      return s;
   endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
   import ccr_pkg::*;
#(
   parameter int unsigned AW     = 4,
   parameter int unsigned A_PROT = 0,
   parameter int unsigned A_CLKA = 1,
   parameter int unsigned A_CLKB = 2,
   parameter int unsigned A_OSCD = 3,
   parameter int unsigned A_PLL  = 4,
   parameter int unsigned A_PCLK = 5,
   parameter int unsigned A_MODE = 6
) (
   input  logic [AW-1:0] addr,
   output sel_e          sel
);

   localparam int unsigned AMAP [NREG] = '{A_PROT, A_CLKA, A_CLKB, A_OSCD,
                                          A_PLL, A_PCLK, A_MODE};

   logic [NREG-1:0] hit;

   for (genvar g = 0; g < NREG; g++) begin : g_hit
      if (AMAP[g] >= (2 ** AW)) begin : g_range
         $error("ccr_decode: address out of range");
      end
      for (genvar h = g + 1; h < NREG; h++) begin : g_uniq
         if (AMAP[g] == AMAP[h]) begin : g_dup
            $error("ccr_decode: duplicate register address");
         end
      end
      assign hit[g] = (addr == AW'(AMAP[g]));
   end

   always_comb begin
      sel = SEL_NONE;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) sel = sel_e'(3'(i + 1));
      end
   end

endmodule

// File: rtl/ccr_rules.sv
module ccr_rules
   import ccr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned MULT_W = 3,
   localparam int unsigned DA_W  = DW - 4
) (
   input  logic              wr_en,
   input  sel_e              sel,
   input  logic [DW-1:0]     wdata,
   input  ccr_state_t        cur,
   input  logic [DA_W-1:0]   cur_div_a,
   input  logic [MULT_W-1:0] cur_mult,
   input  logic [1:0]        cur_prot,
   output ccr_state_t        nxt,
   output logic [DA_W-1:0]   nxt_div_a,
   output logic [MULT_W-1:0] nxt_mult,
   output logic [1:0]        nxt_prot,
   output logic              blocked,
   output logic              stop_req
);

   logic clk_ok, mode_ok;
   assign clk_ok  = cur_prot[0];
   assign mode_ok = cur_prot[1];

   always_comb begin
      nxt       = cur;
      nxt_div_a = cur_div_a;
      nxt_mult  = cur_mult;
      nxt_prot  = cur_prot;
      blocked   = 1'b0;
      stop_req  = 1'b0;
      if (wr_en) begin
         case (sel)
            SEL_PROT: nxt_prot = wdata[1:0];
            SEL_CLKA: begin
               if (!clk_ok) blocked = 1'b1;
               else begin
                  nxt_div_a = wdata[DW-1:4];
                  if (cur.lock) begin
                     if (wdata[2:0] != {cur.cpu_a, cur.main_keep, cur.main_stop})
                        blocked = 1'b1;
                  end else begin
                     nxt.main_stop = wdata[0];
                     nxt.main_keep = wdata[1];
                     nxt.cpu_a     = wdata[2];
                  end
               end
            end
            SEL_CLKB: begin
               if (!clk_ok) blocked = 1'b1;
               else begin
                  nxt.div_b = wdata[3:2];
                  if (cur.lock) begin
                     if (wdata[1] != cur.cpu_b) blocked = 1'b1;
                  end else begin
                     nxt.cpu_b = wdata[1];
                  end
                  if (wdata[0]) begin
                     if (cur.lock || cur.wdt_osc) blocked = 1'b1;
                     else stop_req = 1'b1;
                  end
               end
            end
            SEL_OSCD: begin
               if (!clk_ok) blocked = 1'b1;
               else if (cur.lock) begin
                  if (wdata[0] != cur.det_en) blocked = 1'b1;
               end else begin
                  nxt.det_en = wdata[0];
               end
            end
            SEL_PLL: begin
               if (!clk_ok) blocked = 1'b1;
               else if (cur.lock) begin
                  if (wdata[MULT_W:0] != {cur_mult, cur.pll_on}) blocked = 1'b1;
               end else begin
                  nxt.pll_on = wdata[0];
                  nxt_mult   = wdata[MULT_W:1];
               end
            end
            SEL_PCLK: begin
               if (!clk_ok) blocked = 1'b1;
               else begin
                  nxt.tmr_full = wdata[0];
                  nxt.ser_full = wdata[1];
               end
            end
            SEL_MODE: begin
               if (!mode_ok) blocked = 1'b1;
               else begin
                  if (cur.pll_on) begin
                     if (wdata[0] != cur.wait1) blocked = 1'b1;
                  end else begin
                     nxt.wait1 = wdata[0];
                  end
                  if (cur.lock && !wdata[1])    blocked = 1'b1;
                  if (cur.wdt_osc && !wdata[2]) blocked = 1'b1;
                  nxt.lock    = cur.lock    | wdata[1];
                  nxt.wdt_osc = cur.wdt_osc | wdata[2];
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ccr_readmux.sv
module ccr_readmux
   import ccr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned MULT_W = 3,
   localparam int unsigned DA_W  = DW - 4
) (
   input  sel_e              sel,
   input  ccr_state_t        st,
   input  logic [DA_W-1:0]   div_a,
   input  logic [MULT_W-1:0] mult,
   input  logic [1:0]        prot,
   output logic [DW-1:0]     rd_data
);

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_PROT: rd_data[1:0]      = prot;
         SEL_CLKA: begin
            rd_data[0]               = st.main_stop;
            rd_data[1]               = st.main_keep;
            rd_data[2]               = st.cpu_a;
            rd_data[DW-1:4]          = div_a;
         end
         SEL_CLKB: begin
            rd_data[1]               = st.cpu_b;
            rd_data[3:2]             = st.div_b;
         end
         SEL_OSCD: rd_data[0]        = st.det_en;
         SEL_PLL:  rd_data[MULT_W:0] = {mult, st.pll_on};
         SEL_PCLK: rd_data[1:0]      = {st.ser_full, st.tmr_full};
         SEL_MODE: rd_data[2:0]      = {st.wdt_osc, st.lock, st.wait1};
         default: ;
      endcase
   end

endmodule

// File: rtl/ccr_bank.sv
module ccr_bank
   import ccr_pkg::*;
#(
   parameter int unsigned AW     = 4,
   parameter int unsigned DW     = 8,
   parameter int unsigned MULT_W = 3,
   parameter int unsigned A_PROT = 0,
   parameter int unsigned A_CLKA = 1,
   parameter int unsigned A_CLKB = 2,
   parameter int unsigned A_OSCD = 3,
   parameter int unsigned A_PLL  = 4,
   parameter int unsigned A_PCLK = 5,
   parameter int unsigned A_MODE = 6,
   localparam int unsigned DA_W  = DW - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     rd_data,
   output logic              main_stop,
   output logic              main_keep,
   output logic [1:0]        cpu_src,
   output logic [DA_W-1:0]   div_a,
   output logic [1:0]        div_b,
   output logic              osc_det_en,
   output logic              pll_on,
   output logic [MULT_W-1:0] pll_mult,
   output logic              tmr_full,
   output logic              ser_full,
   output logic              sfr_one_wait,
   output logic              clk_locked,
   output logic              wdt_src_osc,
   output logic              stop_go,
   output logic              wr_blocked
);

   if (DW < 8) begin : g_dw_chk
      $error("ccr_bank: DW must be at least 8");
   end
   if (MULT_W < 1 || MULT_W + 1 > DW) begin : g_mult_chk
      $error("ccr_bank: MULT_W must fit beside the PLL enable");
   end

   sel_e              sel;
   ccr_state_t        st_q, st_d;
   logic [DA_W-1:0]   diva_q, diva_d;
   logic [MULT_W-1:0] mult_q, mult_d;
   logic [1:0]        prot_q, prot_d;
   logic              blk_d, blk_q, go_d, go_q;

   ccr_decode #(
      .AW(AW), .A_PROT(A_PROT), .A_CLKA(A_CLKA), .A_CLKB(A_CLKB),
      .A_OSCD(A_OSCD), .A_PLL(A_PLL), .A_PCLK(A_PCLK), .A_MODE(A_MODE)
   ) u_dec (
      .addr(addr),
      .sel (sel)
   );

   ccr_rules #(.DW(DW), .MULT_W(MULT_W)) u_rules (
      .wr_en    (wr_en),
      .sel      (sel),
      .wdata    (wr_data),
      .cur      (st_q),
      .cur_div_a(diva_q),
      .cur_mult (mult_q),
      .cur_prot (prot_q),
      .nxt      (st_d),
      .nxt_div_a(diva_d),
      .nxt_mult (mult_d),
      .nxt_prot (prot_d),
      .blocked  (blk_d),
      .stop_req (go_d)
   );

   ccr_readmux #(.DW(DW), .MULT_W(MULT_W)) u_rd (
      .sel    (sel),
      .st     (st_q),
      .div_a  (diva_q),
      .mult   (mult_q),
      .prot   (prot_q),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ccr_reset_state();
         diva_q <= '0;
         mult_q <= '0;
         prot_q <= '0;
         blk_q  <= 1'b0;
         go_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         diva_q <= diva_d;
         mult_q <= mult_d;
         prot_q <= prot_d;
         blk_q  <= blk_d;
         go_q   <= go_d;
      end
   end

   assign main_stop    = st_q.main_stop;
   assign main_keep    = st_q.main_keep;
   assign cpu_src      = {st_q.cpu_b, st_q.cpu_a};
   assign div_a        = diva_q;
   assign div_b        = st_q.div_b;
   assign osc_det_en   = st_q.det_en;
   assign pll_on       = st_q.pll_on;
   assign pll_mult     = mult_q;
   assign tmr_full     = st_q.tmr_full;
   assign ser_full     = st_q.ser_full;
   assign sfr_one_wait = st_q.wait1 & st_q.pll_on;
   assign clk_locked   = st_q.lock;
   assign wdt_src_osc  = st_q.wdt_osc;
   assign stop_go      = go_q;
   assign wr_blocked   = blk_q;

   assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q.lock) |-> st_q.lock);

   assert_wdt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q.wdt_osc) |-> st_q.wdt_osc);

   assert_no_stop_on_wdt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |-> !$past(st_q.wdt_osc) && !$past(st_q.lock));

   assert_lock_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q.lock) |-> $stable(mult_q) && $stable(st_q.pll_on) &&
                           $stable(st_q.main_stop) && $stable(st_q.main_keep) &&
                           $stable(st_q.cpu_a) && $stable(st_q.cpu_b) &&
                           $stable(st_q.det_en));

   assert_wait_pll_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q.pll_on) |-> $stable(st_q.wait1));

   assert_protect_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prot_q[0]) |-> $stable(mult_q) && $stable(st_q.pll_on) &&
                            $stable(st_q.tmr_full) && $stable(st_q.ser_full) &&
                            $stable(diva_q) && $stable(st_q.div_b) && !go_q);

   assert_protect_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prot_q[1]) |-> $stable(st_q.wait1) && $stable(st_q.lock) &&
                            $stable(st_q.wdt_osc));

   assert_pulse_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_blocked || stop_go) |-> $past(wr_en));

endmodule

// File: tb/sim_ccr_bank.sv
module sim_ccr_bank;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int MW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          main_stop, main_keep, osc_det_en, pll_on, tmr_full, ser_full;
   logic          sfr_one_wait, clk_locked, wdt_src_osc, stop_go, wr_blocked;
   logic [1:0]    cpu_src, div_b;
   logic [3:0]    div_a;
   logic [MW-1:0] pll_mult;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   ccr_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .main_stop(main_stop), .main_keep(main_keep),
      .cpu_src(cpu_src), .div_a(div_a), .div_b(div_b), .osc_det_en(osc_det_en),
      .pll_on(pll_on), .pll_mult(pll_mult), .tmr_full(tmr_full),
      .ser_full(ser_full), .sfr_one_wait(sfr_one_wait), .clk_locked(clk_locked),
      .wdt_src_osc(wdt_src_osc), .stop_go(stop_go), .wr_blocked(wr_blocked)
   );

   // behavioural reference: plain integer registers, indexed by address
   int m_reg [7];
   int m_blk = 0;
   int m_go  = 0;

   task automatic m_reset();
      for (int i = 0; i < 7; i++) m_reg[i] = 0;
      m_reg[5] = 3;
      m_blk = 0;
      m_go  = 0;
   endtask

   initial m_reset();

   function automatic bit differs(int a, int b, int mask);
      return ((a ^ b) & mask) != 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         int a, d, lk, wd, pl;
         a = int'(addr); d = int'(wr_data);
         lk = (m_reg[6] >> 1) & 1; wd = (m_reg[6] >> 2) & 1; pl = m_reg[4] & 1;
         m_blk = 0; m_go = 0;
         if (wr_en) begin
            if (a == 0) m_reg[0] = d & 3;
            else if (a >= 1 && a <= 5 && (m_reg[0] & 1) == 0) m_blk = 1;
            else if (a == 6 && (m_reg[0] & 2) == 0) m_blk = 1;
            else if (a == 1) begin
               if (lk == 1) begin
                  if (differs(d, m_reg[1], 7)) m_blk = 1;
                  m_reg[1] = (m_reg[1] & 7) | (d & 'hF0);
               end else m_reg[1] = d & 'hF7;
            end else if (a == 2) begin
               if (lk == 1 && differs(d, m_reg[2], 2)) m_blk = 1;
               m_reg[2] = (lk == 1) ? ((m_reg[2] & 2) | (d & 'hC)) : (d & 'hE);
               if ((d & 1) != 0) begin
                  if (lk == 1 || wd == 1) m_blk = 1; else m_go = 1;
               end
            end else if (a == 3) begin
               if (lk == 1) begin if (differs(d, m_reg[3], 1)) m_blk = 1; end
               else m_reg[3] = d & 1;
            end else if (a == 4) begin
               if (lk == 1) begin if (differs(d, m_reg[4], 'hF)) m_blk = 1; end
               else m_reg[4] = d & 'hF;
            end else if (a == 5) m_reg[5] = d & 3;
            else if (a == 6) begin
               int nv;
               nv = m_reg[6];
               if (pl == 1) begin if (differs(d, nv, 1)) m_blk = 1; end
               else nv = (nv & 6) | (d & 1);
               if (lk == 1 && (d & 2) == 0) m_blk = 1;
               if (wd == 1 && (d & 4) == 0) m_blk = 1;
               m_reg[6] = nv | (d & 6);
            end
         end
      end
   end

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the stimulus edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         int a;
         a = int'(addr);
         check("R7 rd_data",  int'(rd_data), (a < 7) ? m_reg[a] : 0);
         check("R8 blocked",  int'(wr_blocked), m_blk);
         check("R9 stop_go",  int'(stop_go), m_go);
         check("R4 clkA",     int'({div_a, 1'b0, cpu_src[0], main_keep, main_stop}), m_reg[1]);
         check("R4 clkB",     int'({div_b, cpu_src[1], 1'b0}), m_reg[2]);
         check("R4 det",      int'(osc_det_en), m_reg[3]);
         check("R4 pll",      int'({pll_mult, pll_on}), m_reg[4]);
         check("R2 pclk",     int'({ser_full, tmr_full}), m_reg[5]);
         check("R6 one_wait", int'(sfr_one_wait), m_reg[6] & m_reg[4] & 1);
         check("R3 mode",     int'({wdt_src_osc, clk_locked}), (m_reg[6] >> 1) & 3);
      end
   end

   logic p_blk, p_go;

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
      p_blk = wr_blocked; p_go = stop_go;
   endtask

   task automatic rd(int a, output int v);
      addr = AW'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(5, v); check("R1 pclk reset", v, 'h03);
      rd(6, v); check("R1 mode reset", v, 0);
      rd(1, v); check("R1 clkA reset", v, 0);
      check("R1 tmr_full reset", int'(tmr_full), 1);

      wr(5, 0);  check("R2 blocked pulse", int'(p_blk), 1);
      rd(5, v);  check("R2 pclk kept", v, 3);
      @(negedge clk); check("R8 pulse one cycle", int'(wr_blocked), 0);
      wr(0, 1);  wr(5, 0); check("R8 no pulse on accept", int'(p_blk), 0);
      rd(5, v);  check("R2 pclk written", v, 0);
      wr(5, 'hFE); rd(5, v); check("R7 reserved zero", v, 2);
      wr(6, 1);  check("R2 mode blocked", int'(p_blk), 1);
      rd(6, v);  check("R2 mode kept", v, 0);

      wr(0, 3);  wr(4, 1); wr(6, 1);
      check("R6 wait blocked pll on", int'(p_blk), 1);
      rd(6, v);  check("R6 wait kept", v, 0);
      wr(4, 0);  wr(6, 1); rd(6, v); check("R6 wait set pll off", v, 1);
      check("R6 no effect pll off", int'(sfr_one_wait), 0);
      wr(4, 1);  check("R6 one wait active", int'(sfr_one_wait), 1);

      wr(2, 1);  check("R9 stop pulse", int'(p_go), 1);
      rd(2, v);  check("R9 bit reads 0", v, 0);

      wr(6, 3);  check("R3 lock set no block", int'(p_blk), 0);
      rd(6, v);  check("R3 lock read", v, 3);
      wr(1, 'h37); check("R4 clkA blocked", int'(p_blk), 1);
      rd(1, v);  check("R4 clkA divider only", v, 'h30);
      wr(4, 'hE); rd(4, v); check("R4 pll frozen", v, 1);
      wr(3, 1);  rd(3, v); check("R4 det frozen", v, 0);
      wr(5, 3);  rd(5, v); check("R4 pclk free", v, 3);
      wr(6, 1);  check("R3 clear refused", int'(p_blk), 1);
      rd(6, v);  check("R3 lock sticky", v, 3);
      wr(2, 1);  check("R9 stop under lock", int'(p_go), 0);

      do_reset();
      rd(6, v);  check("R3 reset clears lock", v, 0);
      wr(0, 3);  wr(6, 4); rd(6, v); check("R5 wdt set", v, 4);
      wr(2, 1);  check("R5 stop refused", int'(p_go), 0);
      check("R5 stop refusal pulses", int'(p_blk), 1);
      wr(1, 7);  rd(1, v); check("R5 clkA not locked", v, 7);
      wr(6, 0);  rd(6, v); check("R5 wdt sticky", v, 4);

      wr(15, 'hFF); check("R10 no pulse", int'(p_blk), 0);
      rd(15, v); check("R10 unmapped reads 0", v, 0);
      rd(5, v);  check("R10 pclk intact", v, 3);
      rd(1, v);  check("R10 clkA intact", v, 7);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule